// File: doc/BRIEF.md
# Four-Entry Fully-Associative Lookup Store with Stamp-Based LRU

This block is a small read-only lookup store holding four 32-bit words. A requester presents a 64-bit byte address; the block compares the word-level tag (address bits [63:2]) against every entry at once. On a match it returns the stored word one cycle later. On a mismatch it fetches the word from a backing memory over a simple request/acknowledge port and installs it in a chosen entry.

Recency is kept by stamping entries with a running access count. An empty entry is always filled first, lowest index first. Once all entries are in use, the entry carrying the smallest stamp is replaced. Running totals of accesses, matches and fetches are presented as outputs.

Top module: `lru_tagstore`

## Requirements
- R1: A synchronous active-high reset clears every valid flag, every stamp and all three totals, and drives `busy`, `done` and `mem_req` low; the first access after reset is therefore a miss.
- R2: An access hits only when some entry is valid and its stored tag equals address bits [63:2]; bits [1:0] never affect the outcome. On a hit, `done` and `hit` are high in the cycle after acceptance, and `rdata` carries the stored word.
- R3: `ref_count` rises by exactly one for each accepted access. A request is accepted only when `busy` is low and `req_valid` is high; a request raised while `busy` is high is dropped and has no effect on any total.
- R4: On a hit, the matching entry's stamp is overwritten with the new access count, so that entry becomes the most recent one.
- R5: On a miss, when any entry is invalid, the lowest-numbered invalid entry is filled.
- R6: On a miss with all entries valid, the entry with the strictly smallest stamp is replaced; equal stamps resolve to the lowest index.
- R7: After a miss, `busy` and `mem_req` are high from the next cycle until the cycle in which `mem_ack` is seen, with `mem_addr` equal to the access address with bits [1:0] cleared. In the cycle after `mem_ack`, `done` is high, `hit` is low and `rdata` equals the returned `mem_data`. The filled entry then holds the new tag, is valid, and carries the access count as its stamp.
- R8: `hit_count + miss_count` equals `ref_count` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_addr | input | 64 | Byte address of the access |
| busy | output | 1 | High while a fetch is outstanding |
| done | output | 1 | One-cycle pulse marking a finished access |
| hit | output | 1 | Valid with `done`: 1 for hit, 0 for fetched |
| rdata | output | 32 | Returned word, valid with `done` |
| mem_req | output | 1 | Fetch request to the backing memory |
| mem_addr | output | 64 | Word-aligned fetch address |
| mem_ack | input | 1 | Backing memory response strobe |
| mem_data | input | 32 | Word returned with `mem_ack` |
| ref_count | output | 32 | Accesses accepted since reset |
| hit_count | output | 32 | Hits since reset |
| miss_count | output | 32 | Misses since reset |

## Verification
The bench targets the following failures:
- Victim choice. A design that preferred the oldest stamp over an empty entry, or ignored the stamp refresh on a hit, would evict a recently used word, and a later access would miss where a hit is expected.
- Tag width. Tags that differ only in address bit 63 or only in bit 2 are mixed in. A truncated compare would report false hits that return the wrong word.
- Dropped requests and offsets. Requests raised while a fetch is pending must leave the totals unchanged. Reads of the same word at each byte offset must all hit.
- Reset and refill. A reset in mid-run must make a previously held word miss, and a wrongly aligned fetch address would return mismatching data.

// File: rtl/lts_pkg.sv
package lts_pkg;

    localparam int ADDR_W      = 64;
    localparam int DATA_W      = 32;
    localparam int WORD_OFF    = 2;
    localparam int TAG_W       = ADDR_W - WORD_OFF;
    localparam int STAMP_W     = 32;
    localparam int NUM_ENTRIES = 4;
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } state_e;

    // pending fetch: where it goes and what it will carry
    typedef struct packed {
        idx_t   slot;
        tag_t   tag;
        stamp_t stamp;
    } fill_t;

    // combinational lookup outcome
    typedef struct packed {
        logic  found;
        idx_t  slot;
        word_t word;
    } look_t;

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WORD_OFF];
    endfunction

    function automatic logic [ADDR_W-1:0] word_base(input tag_t t);
        return {t, {WORD_OFF{1'b0}}};
    endfunction

endpackage

// File: rtl/lts_match.sv
module lts_match
    import lts_pkg::*;
#(
    parameter int ENTRIES = NUM_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  tag_t               tags  [ENTRIES],
    input  word_t              words [ENTRIES],
    input  tag_t               probe,
    output look_t              result
);

    logic [ENTRIES-1:0] eq_vec;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq_vec[g] = valid[g] && (tags[g] == probe);
        end
    endgenerate

    always_comb begin
        result = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                result.found = 1'b1;
                result.slot  = idx_t'(i);
                result.word  = words[i];
            end
        end
    end

    // Refill happens only on a miss, so no two live entries share a tag.
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eq_vec)); // R2

endmodule

// File: rtl/lts_victim.sv
module lts_victim
    import lts_pkg::*;
#(
    parameter int ENTRIES = NUM_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  stamp_t             stamps [ENTRIES],
    output idx_t               victim
);

    idx_t   free_slot;
    logic   have_free;
    idx_t   old_slot;
    stamp_t old_stamp;

    // lowest-numbered empty entry
    always_comb begin
        have_free = 1'b0;
        free_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_slot = idx_t'(i);
            end
        end
    end

    // smallest stamp, strict compare keeps the lowest index on ties
    always_comb begin
        old_slot  = '0;
        old_stamp = stamps[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (stamps[i] < old_stamp) begin
                old_stamp = stamps[i];
                old_slot  = idx_t'(i);
            end
        end
    end

    assign victim = have_free ? free_slot : old_slot;

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!(&valid)) |-> !valid[victim]); // R5

endmodule

// File: rtl/lts_counters.sv
module lts_counters
    import lts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc_hit,
    input  logic   inc_miss,
    output stamp_t ref_q,
    output stamp_t hit_q,
    output stamp_t miss_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            if (inc_hit || inc_miss) ref_q <= ref_q + 1'b1;
            if (inc_hit)             hit_q <= hit_q + 1'b1;
            if (inc_miss)            miss_q <= miss_q + 1'b1;
        end
    end

    AST_TOTALS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (hit_q + miss_q) == ref_q); // R8

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (ref_q != $past(ref_q)) |-> (ref_q == $past(ref_q) + 1'b1)); // R3

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(inc_hit && inc_miss)); // R3

endmodule

// File: rtl/lru_tagstore.sv
module lru_tagstore
    import lts_pkg::*;
#(
    parameter int ENTRIES = NUM_ENTRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic [STAMP_W-1:0] ref_count,
    output logic [STAMP_W-1:0] hit_count,
    output logic [STAMP_W-1:0] miss_count
);

    // entry storage
    logic [ENTRIES-1:0] valid_q;
    tag_t               tag_q   [ENTRIES];
    stamp_t             stamp_q [ENTRIES];
    word_t              word_q  [ENTRIES];

    state_e state_q;
    fill_t  fill_q;
    logic   done_q;
    logic   hit_q;
    word_t  rdata_q;

    tag_t   probe;
    look_t  look;
    idx_t   victim;
    logic   accept;
    stamp_t stamp_now;
    logic   unused_off;

    assign probe      = tag_of(req_addr);
    assign unused_off = ^req_addr[WORD_OFF-1:0];
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign stamp_now  = ref_count + 1'b1;

    lts_match #(.ENTRIES(ENTRIES)) u_match (
        .clk    (clk),
        .rst    (rst),
        .valid  (valid_q),
        .tags   (tag_q),
        .words  (word_q),
        .probe  (probe),
        .result (look)
    );

    lts_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .valid  (valid_q),
        .stamps (stamp_q),
        .victim (victim)
    );

    lts_counters u_count (
        .clk      (clk),
        .rst      (rst),
        .inc_hit  (accept && look.found),
        .inc_miss (accept && !look.found),
        .ref_q    (ref_count),
        .hit_q    (hit_count),
        .miss_q   (miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]   <= '0;
                stamp_q[i] <= '0;
                word_q[i]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (look.found) begin
                            stamp_q[look.slot] <= stamp_now;
                            done_q             <= 1'b1;
                            hit_q              <= 1'b1;
                            rdata_q            <= look.word;
                        end else begin
                            fill_q.slot  <= victim;
                            fill_q.tag   <= probe;
                            fill_q.stamp <= stamp_now;
                            state_q      <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        valid_q[fill_q.slot] <= 1'b1;
                        tag_q[fill_q.slot]   <= fill_q.tag;
                        stamp_q[fill_q.slot] <= fill_q.stamp;
                        word_q[fill_q.slot]  <= mem_data;
                        done_q               <= 1'b1;
                        hit_q                <= 1'b0;
                        rdata_q              <= mem_data;
                        state_q              <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == ST_FILL);
    assign mem_req  = (state_q == ST_FILL);
    assign mem_addr = word_base(fill_q.tag);
    assign done     = done_q;
    assign hit      = hit_q;
    assign rdata    = rdata_q;

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
        (accept && !look.found) |=> (busy && mem_req)); // R7

    AST_ACK_FINISHES: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack) |=> (done && !hit && !busy)); // R7

    AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (accept && look.found) |=> (done && hit && !busy)); // R2

    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ref_count)); // R3

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !done); // R2

endmodule

// File: tb/lru_tagstore_test.sv
module lru_tagstore_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        busy, done, hit, mem_req, mem_ack;
    logic [31:0] rdata, mem_data;
    logic [63:0] mem_addr;
    logic [31:0] ref_count, hit_count, miss_count;

    int checks = 0;
    int fails  = 0;
    int mem_delay = 1;

    always #4 clk = ~clk;

    lru_tagstore uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .hit(hit), .rdata(rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .ref_count(ref_count), .hit_count(hit_count), .miss_count(miss_count)
    );

    // reference model state
    bit          m_valid [4];
    logic [61:0] m_tag   [4];
    int unsigned m_stamp [4];
    int unsigned m_ref, m_hits;

    function automatic logic [31:0] memf(input logic [63:0] wa);
        return wa[31:0] ^ wa[63:32] ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_stamp[i] = 0;
        end
        m_ref = 0; m_hits = 0;
    endtask

    function automatic bit model_access(input logic [63:0] a);
        logic [61:0] t = a[63:2];
        int v = -1;
        m_ref++;
        for (int i = 0; i < 4; i++)
            if (m_valid[i] && m_tag[i] == t) begin
                m_stamp[i] = m_ref; m_hits++; return 1'b1;
            end
        for (int i = 0; i < 4; i++)
            if (!m_valid[i] && v < 0) v = i;
        if (v < 0) begin
            v = 0;
            for (int i = 1; i < 4; i++)
                if (m_stamp[i] < m_stamp[v]) v = i;
        end
        m_valid[v] = 1; m_tag[v] = t; m_stamp[v] = m_ref;
        return 1'b0;
    endfunction

    // backing memory responder
    initial begin
        int wcnt = 0;
        mem_ack = 0; mem_data = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt + 1 >= mem_delay) begin
                    mem_ack = 1; mem_data = memf(mem_addr);
                end else wcnt++;
            end
        end
    end

    task automatic do_access(input logic [63:0] a, input bit intrude, output bit got_hit);
        bit eh;
        logic [31:0] ed;
        int lat;
        bit saw_busy;
        eh = model_access(a);
        ed = memf({a[63:2], 2'b00});
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0; lat = 1; saw_busy = 0;
        while (!done && lat < 60) begin
            if (busy) saw_busy = 1;
            if (intrude && busy && lat == 1) begin
                req_valid = 1; req_addr = a ^ 64'h40;
            end else req_valid = 0;
            @(negedge clk);
            lat++;
        end
        req_valid = 0;
        got_hit = hit;
        chk(done, "R7", "access finished", done, 1);
        chk(hit == eh, "R2 R4 R5 R6", "hit flag", hit, eh);
        chk(rdata == ed, "R2 R7", "read data", rdata, ed);
        if (eh) chk(lat == 1, "R2", "hit latency", lat, 1);
        else    chk(saw_busy, "R7", "busy during fetch", saw_busy, 1);
        chk(ref_count == m_ref, "R3", "access total", ref_count, m_ref);
        chk(hit_count == m_hits, "R3", "hit total", hit_count, m_hits);
        chk(hit_count + miss_count == ref_count, "R8", "totals sum",
            hit_count + miss_count, ref_count);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1; req_valid = 0;
        @(negedge clk); @(negedge clk); rst = 0;
        model_reset();
        chk(!busy && !done && !mem_req, "R1", "idle outputs", {busy, done, mem_req}, 0);
        chk(ref_count == 0 && hit_count == 0 && miss_count == 0, "R1", "totals cleared",
            ref_count + hit_count + miss_count, 0);
    endtask

    logic [63:0] pool [6];

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit h;
        logic [15:0] lfsr = 16'hACE1;
        rst = 1; req_valid = 0; req_addr = '0;
        pool[0] = 64'h0000_0000_0000_0000;
        pool[1] = 64'h8000_0000_0000_0000;  // differs only in bit 63
        pool[2] = 64'h0000_0000_0000_0004;  // differs only in bit 2
        pool[3] = 64'h1234_5678_9ABC_DEF0;
        pool[4] = 64'h0000_0100_0000_0010;
        pool[5] = 64'hFFFF_FFFF_FFFF_FFFC;
        apply_reset();

        // R1: first access after reset misses
        do_access(64'h0, 0, h);
        chk(!h, "R1", "cold miss after reset", h, 0);

        // R2: each byte offset of the same word hits
        for (int o = 1; o < 4; o++) begin
            do_access(64'h0 | o, 0, h);
            chk(h, "R2", "offset ignored", h, 1);
        end

        // R5: fill the remaining empty entries, then prove all four are held
        do_access(pool[1], 0, h);
        do_access(pool[2], 0, h);
        do_access(pool[3], 0, h);
        do_access(pool[0] | 64'h2, 0, h);
        chk(h, "R5", "empty entries used first", h, 1);

        // R4 R6: refresh pool[1], then a new tag must evict pool[2] (oldest)
        do_access(pool[1], 0, h);
        do_access(pool[4], 0, h);
        chk(!h, "R6", "new tag misses", h, 0);
        do_access(pool[1], 0, h);
        chk(h, "R4", "refreshed entry kept", h, 1);
        do_access(pool[2], 0, h);
        chk(!h, "R6", "oldest entry evicted", h, 0);

        // R3: request raised during a fetch is dropped
        mem_delay = 4;
        do_access(pool[5], 1, h);
        chk(!h, "R3", "intruded fetch still a miss", h, 0);
        do_access(pool[5] ^ 64'h40, 0, h);
        chk(!h, "R3", "dropped request installed nothing", h, 0);

        // R1: reset mid-run forgets everything
        apply_reset();
        do_access(pool[5], 0, h);
        chk(!h, "R1", "held word forgotten", h, 0);

        // mixed sweep over six tags, random offsets and fetch latencies
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_delay = 1 + (lfsr[9:8] % 3);
            do_access(pool[lfsr[7:0] % 6] | 64'(lfsr[11:10]), (n % 37) == 5, h);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule